// File: doc/BRIEF.md
# Low-Frequency Watchdog Timer with Power-of-Two Postscaler

This block supervises software progress by counting ticks of a free-running low-frequency oscillator. A fixed divide-by-128 base stage produces a base period, nominally 4 ms. A postscaler then counts base periods up to a ratio of 2^sel, where `post_sel` is a 4-bit field. The total timeout therefore spans 4 ms at sel = 0 up to 131.072 s at sel = 15. Software keeps the device alive by issuing the clear strobe before the timeout expires.

The watchdog runs while either the hardware enable or the software enable is high. Several events restart both counters: the clear strobe, entry into sleep, any change of the oscillator frequency-select field, and an asserted clock-failure flag. When the timeout expires during normal running, the block pulses a reset request. When it expires while the device sleeps, it pulses a wake-up instead.

Top module: `lfo_watchdog`

## Requirements
- R1: With select value s held constant, a timeout occurs after exactly 128·2^s accepted ticks of `lfo_tick` since the last clear. The output pulse is high in the clock cycle that follows the edge sampling the final tick.
- R2: `post_sel` (0..15) chooses a ratio of 2^s. If it is lowered below the base periods already counted, the timeout fires at the next base-period boundary (every 128 accepted ticks).
- R3: A high `clr_cmd` in a cycle restarts both counters from zero.
- R4: A high `sleep_enter` in a cycle restarts both counters from zero.
- R5: A `fsel` value that differs from its value in the previous cycle restarts both counters. The reference value after reset is 0. A high `clk_fail` restarts both counters in every cycle it is high.
- R6: The counters run only while `hw_en` or `sw_en` is 1. While both are 0, the counters are held at zero and no pulse is produced.
- R7: A timeout with `in_sleep` = 0 produces a one-cycle high pulse on `rst_req`.
- R8: A timeout with `in_sleep` = 1 produces a one-cycle high pulse on `wake_pulse`. The two outputs are never high together.
- R9: After either kind of timeout, the counters restart from zero, and the next timeout needs a full period again.
- R10: A low `rst_n` (asynchronous) clears both counters and both outputs.
- R11: A restart event in the same cycle as a tick wins: that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low device reset |
| lfo_tick | input | 1 | One-cycle strobe per low-frequency oscillator period |
| hw_en | input | 1 | Hardware enable (from configuration) |
| sw_en | input | 1 | Software enable |
| post_sel | input | 4 | Postscaler select, ratio 2^post_sel |
| clr_cmd | input | 1 | Clear command strobe |
| sleep_enter | input | 1 | Sleep entry strobe |
| fsel | input | 3 | Oscillator frequency-select field |
| clk_fail | input | 1 | Clock failure flag |
| in_sleep | input | 1 | Device is in a sleep or power-managed mode |
| rst_req | output | 1 | One-cycle reset request on timeout while running |
| wake_pulse | output | 1 | One-cycle wake-up on timeout while sleeping |

## Verification
The bench attacks the exact expiry tick at the small select values. An off-by-one base or postscaler terminal would move the pulse a whole base period or a single tick. It also lowers `post_sel` in the middle of a count. A design that compares for equality only would wrap its postscaler and stay silent for up to 2^15 base periods. Restart events are made to coincide with ticks, and `fsel` is toggled both by one cycle and by holding a new value. A design that counts the colliding tick, or that restarts on every cycle of a held new `fsel`, drifts away from the reference count. Timeouts under `in_sleep` show whether the output is steered to the right pin.

// File: rtl/lfo_wdt_pkg.sv
package lfo_wdt_pkg;

    // Registered output stage of the watchdog
    typedef struct packed {
        logic rst_req;
        logic wake;
    } wdt_out_t;

endpackage

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl #(
    parameter int FSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hw_en,
    input  logic              sw_en,
    input  logic              clr_cmd,
    input  logic              sleep_enter,
    input  logic              clk_fail,
    input  logic [FSEL_W-1:0] fsel,
    output logic              clr
);

    typedef struct packed {
        logic [FSEL_W-1:0] fsel;
    } ctl_st_t;

    ctl_st_t st_d, st_q;
    logic    fsel_moved;

    always_comb begin
        st_d       = st_q;
        st_d.fsel  = fsel;
        fsel_moved = (fsel != st_q.fsel);
        clr        = ~(hw_en | sw_en) | clr_cmd | sleep_enter | clk_fail | fsel_moved;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R4: sleep entry always produces a restart
    p_sleep_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_enter |-> clr);

endmodule

// File: rtl/wdt_base_div.sv
module wdt_base_div #(
    parameter int BASE_DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic clr,
    output logic base_wrap
);

    localparam int BASE_W = $clog2(BASE_DIV);

    typedef struct packed {
        logic [BASE_W-1:0] cnt;
    } base_st_t;

    base_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        base_wrap = tick & ~clr & (st_q.cnt == BASE_W'(BASE_DIV - 1));
        if (clr)            st_d.cnt = '0;
        else if (base_wrap) st_d.cnt = '0;
        else if (tick)      st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a restart leaves the base counter at zero
    p_base_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

    // R11: a tick colliding with a restart is not counted
    p_tick_lost_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && tick) |=> (st_q.cnt == '0));

endmodule

// File: rtl/wdt_post_div.sv
module wdt_post_div #(
    parameter int SEL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_wrap,
    input  logic             clr,
    input  logic [SEL_W-1:0] sel,
    output logic             expire
);

    localparam int POST_W = (1 << SEL_W) - 1;

    typedef struct packed {
        logic [POST_W-1:0] cnt;
    } post_st_t;

    post_st_t          st_d, st_q;
    logic [POST_W:0]   ratio;
    logic [POST_W-1:0] last;

    always_comb begin
        st_d   = st_q;
        ratio  = (POST_W + 1)'(1) << sel;
        last   = POST_W'(ratio - 1'b1);
        expire = base_wrap & (st_q.cnt >= last);
        if (clr)            st_d.cnt = '0;
        else if (expire)    st_d.cnt = '0;
        else if (base_wrap) st_d.cnt = st_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: postscaler restarts after a timeout
    p_post_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (st_q.cnt == '0));

    // R3: a restart leaves the postscaler at zero
    p_post_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (st_q.cnt == '0));

endmodule

// File: rtl/lfo_watchdog.sv
module lfo_watchdog
    import lfo_wdt_pkg::*;
#(
    parameter int BASE_DIV = 128,
    parameter int SEL_W    = 4,
    parameter int FSEL_W   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lfo_tick,
    input  logic              hw_en,
    input  logic              sw_en,
    input  logic [SEL_W-1:0]  post_sel,
    input  logic              clr_cmd,
    input  logic              sleep_enter,
    input  logic [FSEL_W-1:0] fsel,
    input  logic              clk_fail,
    input  logic              in_sleep,
    output logic              rst_req,
    output logic              wake_pulse
);

    logic     clr;
    logic     base_wrap;
    logic     expire;
    wdt_out_t out_d, out_q;

    wdt_clear_ctl #(.FSEL_W(FSEL_W)) u_clear (
        .clk        (clk),
        .rst_n      (rst_n),
        .hw_en      (hw_en),
        .sw_en      (sw_en),
        .clr_cmd    (clr_cmd),
        .sleep_enter(sleep_enter),
        .clk_fail   (clk_fail),
        .fsel       (fsel),
        .clr        (clr)
    );

    wdt_base_div #(.BASE_DIV(BASE_DIV)) u_base (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (lfo_tick),
        .clr      (clr),
        .base_wrap(base_wrap)
    );

    wdt_post_div #(.SEL_W(SEL_W)) u_post (
        .clk      (clk),
        .rst_n    (rst_n),
        .base_wrap(base_wrap),
        .clr      (clr),
        .sel      (post_sel),
        .expire   (expire)
    );

    always_comb begin
        out_d         = out_q;
        out_d.rst_req = expire & ~in_sleep;
        out_d.wake    = expire & in_sleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rst_req    = out_q.rst_req;
    assign wake_pulse = out_q.wake;

    // R8: the two outputs are mutually exclusive
    p_excl_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rst_req && wake_pulse));

    // R7: reset request lasts a single cycle
    p_rst_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R8: wake-up lasts a single cycle
    p_wake_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wake_pulse |=> !wake_pulse);

    // R6: disabled watchdog produces no pulse
    p_disabled_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hw_en || sw_en) |=> !(rst_req || wake_pulse));

    // R5: clock failure suppresses any timeout
    p_fail_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clk_fail |=> !(rst_req || wake_pulse));

    // R7: a reset request only follows a non-sleeping cycle
    p_rst_awake_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(!in_sleep));

endmodule

// File: tb/lfo_watchdog_tb.sv
module lfo_watchdog_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       lfo_tick = 1'b0, hw_en = 1'b0, sw_en = 1'b0;
    logic [3:0] post_sel = '0;
    logic       clr_cmd = 1'b0, sleep_enter = 1'b0, clk_fail = 1'b0, in_sleep = 1'b0;
    logic [2:0] fsel = '0;
    logic       rst_req, wake_pulse;

    int    total = 0, bad = 0, cycles = 0;
    string phase = "R10 reset";

    // reference model state
    int         m_cnt = 0;
    logic [2:0] m_fsel_prev = '0;
    logic       exp_r = 1'b0, exp_w = 1'b0;
    int         n_rst = 0, n_wake = 0;

    always #2 clk = ~clk;

    lfo_watchdog u_dut (
        .clk(clk), .rst_n(rst_n), .lfo_tick(lfo_tick), .hw_en(hw_en), .sw_en(sw_en),
        .post_sel(post_sel), .clr_cmd(clr_cmd), .sleep_enter(sleep_enter), .fsel(fsel),
        .clk_fail(clk_fail), .in_sleep(in_sleep), .rst_req(rst_req), .wake_pulse(wake_pulse)
    );

    function automatic int period(input logic [3:0] s);
        return 128 << s;
    endfunction

    task automatic check(input string what, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0b expected=%0b at cycle %0d", phase, what, act, exp, cycles);
        end
    endtask

    // Reference: one clock edge of the specified behaviour
    task automatic model_edge();
        logic restart;
        exp_r = 1'b0; exp_w = 1'b0;
        if (!rst_n) begin
            m_cnt = 0; m_fsel_prev = '0;
            return;
        end
        restart = !(hw_en || sw_en) || clr_cmd || sleep_enter || clk_fail || (fsel != m_fsel_prev);
        m_fsel_prev = fsel;
        if (restart) m_cnt = 0;
        else if (lfo_tick) begin
            m_cnt++;
            if ((m_cnt % 128) == 0 && m_cnt >= period(post_sel)) begin
                m_cnt = 0;
                exp_r = !in_sleep;
                exp_w = in_sleep;
            end
        end
    endtask

    task automatic step();
        @(posedge clk);
        cycles++;
        model_edge();
        @(negedge clk);
        check("rst_req (R7)", rst_req, exp_r);
        check("wake_pulse (R8)", wake_pulse, exp_w);
        if (rst_req === 1'b1) n_rst++;
        if (wake_pulse === 1'b1) n_wake++;
    endtask

    task automatic run_ticks(input int n);
        for (int i = 0; i < n; i++) begin
            lfo_tick = 1'b1; step();
        end
        lfo_tick = 1'b0;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : stim
        int unsigned seed;
        int          c0;
        seed = $urandom(32'd5150);
        @(negedge clk);
        step(); step();
        check("R10 reset rst_req low", rst_req, 1'b0);
        check("R10 reset wake low", wake_pulse, 1'b0);
        rst_n = 1'b1;
        hw_en = 1'b1;

        // R1: sel 0, exact expiry after 128 ticks
        phase = "R1 base expiry sel0";
        step();
        c0 = n_rst;
        run_ticks(127);
        check("R1 no pulse at 127 ticks", rst_req, 1'b0);
        run_ticks(1);
        check("R1 pulse after 128th tick", rst_req, 1'b1);
        step();
        check("R7 pulse single cycle", rst_req, 1'b0);

        // R9: next timeout needs full period again
        phase = "R9 restart";
        run_ticks(127);
        check("R9 no early pulse", rst_req, 1'b0);
        run_ticks(1);
        check("R9 full period pulse", rst_req, 1'b1);

        // R2: sel 2 -> 512 ticks
        phase = "R2 ratio sel2";
        post_sel = 4'd2; clr_cmd = 1'b1; step(); clr_cmd = 1'b0;
        run_ticks(511);
        check("R2 no pulse at 511", rst_req, 1'b0);
        run_ticks(1);
        check("R2 pulse at 512", rst_req, 1'b1);

        // R2: lowering select mid-count
        phase = "R2 lowered select";
        post_sel = 4'd3;
        run_ticks(128 * 5);
        post_sel = 4'd1;
        run_ticks(127);
        check("R2 waits for boundary", rst_req, 1'b0);
        run_ticks(1);
        check("R2 fires at boundary", rst_req, 1'b1);

        // R3 / R11: clear colliding with tick
        phase = "R3 R11 clear";
        post_sel = 4'd0;
        run_ticks(100);
        clr_cmd = 1'b1; lfo_tick = 1'b1; step(); clr_cmd = 1'b0;
        run_ticks(127);
        check("R11 colliding tick ignored", rst_req, 1'b0);
        run_ticks(1);
        check("R3 pulse after fresh count", rst_req, 1'b1);

        // R4: sleep entry, then R8 wake
        phase = "R4 R8 sleep";
        run_ticks(90);
        sleep_enter = 1'b1; step(); sleep_enter = 1'b0;
        in_sleep = 1'b1;
        run_ticks(127);
        check("R4 count restarted", wake_pulse, 1'b0);
        run_ticks(1);
        check("R8 wake pulse", wake_pulse, 1'b1);
        check("R8 no reset while asleep", rst_req, 1'b0);
        in_sleep = 1'b0;

        // R5: fsel change, clk_fail
        phase = "R5 fsel and clk_fail";
        run_ticks(120);
        fsel = 3'd5; step();
        run_ticks(127);
        check("R5 fsel change restarts", rst_req, 1'b0);
        run_ticks(1);
        check("R5 held fsel counts normally", rst_req, 1'b1);
        run_ticks(120);
        clk_fail = 1'b1; run_ticks(5); clk_fail = 1'b0;
        run_ticks(127);
        check("R5 clk_fail restarts", rst_req, 1'b0);

        // R6: disabled, then software enable alone
        phase = "R6 enable";
        hw_en = 1'b0;
        run_ticks(400);
        check("R6 disabled no pulse", rst_req, 1'b0);
        sw_en = 1'b1;
        run_ticks(128);
        check("R6 sw_en runs", rst_req, 1'b1);

        // R10: reset mid-count
        phase = "R10 reset mid-count";
        fsel = 3'd0; step();
        run_ticks(100);
        rst_n = 1'b0; step(); rst_n = 1'b1;
        run_ticks(127);
        check("R10 counters cleared", rst_req, 1'b0);
        run_ticks(1);
        check("R10 full period after reset", rst_req, 1'b1);

        // Random phase against reference model
        phase = "R1 R2 R3 R4 R5 R6 R7 R8 random";
        c0 = n_rst + n_wake;
        for (int seg = 0; seg < 60; seg++) begin
            post_sel = 4'($urandom_range(0, 3));
            hw_en    = ($urandom_range(0, 9) != 0);
            sw_en    = ($urandom_range(0, 1) != 0);
            in_sleep = ($urandom_range(0, 2) == 0);
            for (int k = 0; k < 500; k++) begin
                lfo_tick    = ($urandom_range(0, 3) != 0);
                clr_cmd     = ($urandom_range(0, 999) == 0);
                sleep_enter = ($urandom_range(0, 999) == 0);
                clk_fail    = ($urandom_range(0, 1999) == 0);
                if ($urandom_range(0, 1499) == 0) fsel = 3'($urandom);
                step();
            end
        end
        lfo_tick = 1'b0; clr_cmd = 1'b0; sleep_enter = 1'b0; clk_fail = 1'b0;
        check("random run produced timeouts", (n_rst + n_wake) > c0, 1'b1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule